// File: doc/BRIEF.md
# Packed SIMD Media and Carry ALU

This unit is a single-cycle SIMD execution slice for 128-bit vectors. Depending on a two-bit operation code it either treats its operands as sixteen unsigned 8-bit lanes (absolute difference, rounding average) or as four unsigned 32-bit lanes (carry-generate, add-with-carry-in). Every lane is computed independently, and no carry ever crosses from one lane into the next.

Three source vectors arrive together. The vectors `src_a` and `src_b` are the main operands. The vector `src_t` is the current contents of the destination register. Only the add-with-carry-in operation uses it: bit 0 of each word of `src_t` is that lane's carry-in. A carry-generate result is 0 or 1 in bit 0 of its lane, so it can be written back and passed directly to a later add-with-carry-in as `src_t`. Chaining the two in this way builds wide-integer addition.

Results are registered. A strobe on `in_vld` yields `out_vld` and the matching `out_res` one clock later.

Top module: `simd_media_alu`

## Requirements
- R1: With op code 2'b00, each byte lane k (bits 8k+7:8k) of the result is the unsigned absolute difference |A_k − B_k|.
- R2: With op code 2'b01, each byte lane k of the result is (A_k + B_k + 1) >> 1, computed on a 9-bit sum so that no high bit is lost (for example, 0xFF and 0xFF give 0xFF).
- R3: With op code 2'b10, each word lane j (bits 32j+31:32j) of the result holds the carry out of the unsigned 32-bit sum A_j + B_j in bit 0, and bits 31:1 of that lane are zero.
- R4: With op code 2'b11, each word lane j of the result is (A_j + B_j + T_j[0]) mod 2^32, where T is `src_t`. Bits 31:1 of T_j have no effect.
- R5: No carry or borrow crosses a lane boundary in any operation. A lane's result depends only on the same lane of the operands.
- R6: `out_vld` and `out_res` update on the rising clock edge after the inputs are presented, so the latency is one cycle. `out_vld` equals the value `in_vld` had one cycle earlier.
- R7: While `in_vld` is low, `out_res` keeps its previous value.
- R8: When `rst_n` is low at a rising clock edge, `out_vld` is cleared (synchronous, active-low reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operands and op code are valid this cycle |
| op_sel | input | 2 | 00 absdiff, 01 average, 10 carry-generate, 11 add-with-carry-in |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| src_t | input | 128 | Prior destination value; carry-in source for op 11 |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_res | output | 128 | Registered result |

## Verification
Random vectors exercise all four operations together and are compared against lane-by-lane reference functions. Directed patterns target the edges of each lane:
- 0xFF/0x00 in alternating lanes separates the two orders of the absolute-difference subtraction.
- All-ones bytes expose a truncated average sum.
- 0xFFFFFFFF + 1 separates a true carry-out from a carry leaking into the next word.
- A `src_t` with upper bits set but bit 0 clear shows that only bit 0 feeds the add.
- Idle cycles with changing inputs confirm that the result is held.

// File: rtl/simd_media_alu.sv
module simd_media_alu #(
  parameter int VEC_W  = 128,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [1:0]       op_sel,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] src_t,
  output logic             out_vld,
  output logic [VEC_W-1:0] out_res
);
  localparam int NBYTE = VEC_W / BYTE_W;
  localparam int NWORD = VEC_W / WORD_W;

  logic [VEC_W-1:0] abs_v, avg_v, cg_v, addx_v, nxt;

  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    logic [BYTE_W-1:0] a, b;
    logic [BYTE_W:0]   s;
    assign a = src_a[k*BYTE_W +: BYTE_W];
    assign b = src_b[k*BYTE_W +: BYTE_W];
    assign s = {1'b0, a} + {1'b0, b} + 1'b1;
    assign abs_v[k*BYTE_W +: BYTE_W] = (a >= b) ? a - b : b - a;
    assign avg_v[k*BYTE_W +: BYTE_W] = s[BYTE_W:1];
  end

  for (genvar j = 0; j < NWORD; j++) begin : g_word
    logic [WORD_W-1:0] a, b;
    logic [WORD_W:0]   s;
    assign a = src_a[j*WORD_W +: WORD_W];
    assign b = src_b[j*WORD_W +: WORD_W];
    assign s = {1'b0, a} + {1'b0, b};
    assign cg_v[j*WORD_W +: WORD_W]   = {{(WORD_W-1){1'b0}}, s[WORD_W]};
    assign addx_v[j*WORD_W +: WORD_W] = a + b + {{(WORD_W-1){1'b0}}, src_t[j*WORD_W]};
  end

  always_comb begin
    case (op_sel)
      2'b00:   nxt = abs_v;
      2'b01:   nxt = avg_v;
      2'b10:   nxt = cg_v;
      default: nxt = addx_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) out_res <= nxt;
  end
endmodule

module simd_media_alu_chk #(
  parameter int VEC_W  = 128,
  parameter int WORD_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic [1:0]       op_sel,
  input logic [VEC_W-1:0] src_a,
  input logic [VEC_W-1:0] src_b,
  input logic             out_vld,
  input logic [VEC_W-1:0] out_res
);
  localparam int NWORD = VEC_W / WORD_W;
  logic [NWORD-1:0] hi_clear;
  always_comb
    for (int j = 0; j < NWORD; j++)
      hi_clear[j] = (out_res[j*WORD_W+1 +: WORD_W-1] == '0);

  a_r6_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  a_r6_vld_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_res));
  a_r3_cg_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_sel == 2'b10) |=> (&hi_clear));
  a_r1_abs_same_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_sel == 2'b00 && src_a == src_b) |=> (out_res == '0));
  a_r2_avg_same: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_sel == 2'b01 && src_a == src_b) |=> (out_res == $past(src_a)));
  a_r8_reset: assert property (@(posedge clk)
    !rst_n |=> !out_vld);
endmodule

bind simd_media_alu simd_media_alu_chk #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_sel(op_sel),
  .src_a(src_a), .src_b(src_b), .out_vld(out_vld), .out_res(out_res));

// File: tb/test_simd_media_alu.sv
module test_simd_media_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic [127:0] src_a = '0, src_b = '0, src_t = '0;
  logic out_vld;
  logic [127:0] out_res;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  simd_media_alu i_simd_media_alu (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .src_t(src_t),
    .out_vld(out_vld), .out_res(out_res));

  function automatic logic [127:0] ref_res(input logic [1:0] op,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] t);
    logic [127:0] r = '0;
    for (int k = 0; k < 16; k++) begin
      int x = int'(a[k*8 +: 8]);
      int y = int'(b[k*8 +: 8]);
      if (op == 2'b00) r[k*8 +: 8] = 8'((x > y) ? x - y : y - x);
      if (op == 2'b01) r[k*8 +: 8] = 8'((x + y + 1) / 2);
    end
    for (int j = 0; j < 4; j++) begin
      longint x = longint'(a[j*32 +: 32]);
      longint y = longint'(b[j*32 +: 32]);
      longint c = longint'(t[j*32]);
      if (op == 2'b10) r[j*32 +: 32] = (x + y >= 64'h1_0000_0000) ? 32'd1 : 32'd0;
      if (op == 2'b11) r[j*32 +: 32] = 32'(x + y + c);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [1:0] op,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] t);
    @(negedge clk);
    in_vld = 1'b1; op_sel = op; src_a = a; src_b = b; src_t = t;
    @(negedge clk);
    in_vld = 1'b0;
    check({req, " vld"}, {127'd0, out_vld}, 128'd1);
    check(req, out_res, ref_res(op, a, b, t));
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R8 reset vld", {127'd0, out_vld}, 128'd0);
    rst_n = 1'b1;
    issue("R1 absdiff alternating", 2'b00, {8{16'hFF00}}, {8{16'h00FF}}, '0);
    issue("R1 absdiff small", 2'b00, {16{8'h03}}, {16{8'h05}}, '0);
    issue("R2 avg all ones", 2'b01, {16{8'hFF}}, {16{8'hFF}}, '0);
    issue("R2 avg rounding", 2'b01, {16{8'h01}}, {16{8'h02}}, '0);
    issue("R3 carry boundary", 2'b10, {32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h0},
          {32'h1, 32'h80000000, 32'h0, 32'hFFFFFFFF}, '0);
    issue("R4 addx upper t ignored", 2'b11, {4{32'h10}}, {4{32'h20}}, {4{32'hFFFFFFFE}});
    issue("R4 addx carry in", 2'b11, {4{32'h10}}, {4{32'h20}}, {4{32'h1}});
    issue("R5 addx no lane carry", 2'b11, {4{32'hFFFFFFFF}}, {4{32'h0}}, {4{32'h1}});
    issue("R5 cg lanes isolated", 2'b10, {4{32'hFFFFFFFF}}, {4{32'h1}}, '0);
    held = out_res;
    @(negedge clk);
    op_sel = 2'b01; src_a = '1; src_b = '0;
    @(negedge clk);
    check("R7 hold result", out_res, held);
    check("R6 vld drops", {127'd0, out_vld}, 128'd0);
    for (int i = 0; i < 300; i++) begin
      logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] t = {$urandom, $urandom, $urandom, $urandom};
      logic [1:0] op = 2'($urandom);
      issue("R1 R2 R3 R4 random", op, a, b, t);
    end
    @(negedge clk);
    in_vld = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 sync reset", {127'd0, out_vld}, 128'd0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule